// File: doc/BRIEF.md
# Short-Circuit Net-Pair Locator

This block turns an electrical connectivity measurement of a test structure into a list of shorts between its nets. A tester drives each pad in turn and records which other pads respond. Each such row of the pad-by-pad connectivity matrix is fed in. The block removes every connection the fault-free device is meant to have. It maps the remaining pad-level edges onto the nets that own the pads, merges duplicate edges, and keeps a net pair only if the two nets are physical neighbours in the layout. Nets count as neighbours when layout objects of the two lie beside each other, or one above the other, with only insulator between them.

Three tables are loaded through one configuration write port before a measurement: the golden connectivity matrix, the pad-to-net index table and the net neighbour matrix. Measured rows then stream in, and the last row is flagged. The block then walks every net pair once and presents each surviving short on a valid/ready output. A one-cycle done strobe ends the report, and the block is then ready for the next measurement.

Top module: `snl_locator`

## Requirements
- R1: A measured edge from pad i to pad j is dropped when bit j of golden row i (configuration select 0, address i) is set. Only undesigned connections can reach the report.
- R2: A measured edge between two pads whose net indices (configuration select 1, address = pad) are equal never produces a reported pair.
- R3: Any number of undesigned edges that fold onto the same two nets, in either row/column orientation, yield exactly one report of that pair.
- R4: Nets a and b with a < b are reported only when bit b of neighbour row a (configuration select 2, address a) is set. Neighbour bits at or below the diagonal have no effect.
- R5: Reported pairs carry out_first < out_second and come out in ascending order of out_first, then out_second.
- R6: While out_valid is high and out_ready is low, out_valid, out_first and out_second hold their values.
- R7: done pulses for exactly one cycle after the last pair has been accepted, or after the walk when nothing is reported. It is never high together with out_valid, and the next measurement starts from an empty result.
- R8: Measured rows presented after the flagged last row and before done are ignored.
- R9: Edges in the flagged last row are included in the report that row starts.
- R10: After reset, out_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Table select: 0 golden row, 1 pad net index, 2 neighbour row |
| cfg_addr | input | $clog2(NPADS) | Row or pad address |
| cfg_data | input | max(NPADS,NNETS) | Write data (row bits, or net index in low bits) |
| meas_valid | input | 1 | Measured row present |
| meas_row | input | $clog2(NPADS) | Index of the driven pad |
| meas_bits | input | NPADS | Pads that responded |
| meas_last | input | 1 | Marks the final measured row |
| out_valid | output | 1 | A net-pair short is presented |
| out_ready | input | 1 | Consumer accepts the presented pair |
| out_first | output | $clog2(NNETS) | Lower net index of the pair |
| out_second | output | $clog2(NNETS) | Higher net index of the pair |
| done | output | 1 | One-cycle end-of-report strobe |

## Verification
Two pairs of events can fall in the same cycle. First, the flagged last row is folded into the result in the very cycle that the pair walk is armed. The bench places the only short of a run in that last row and requires it in the report. Second, a new row can arrive while the report is running. The bench drives rows of all ones directly behind the last row. They must neither add pairs to the current report nor leave anything behind, which is judged by an empty report on the following measurement. Random runs with a stalling consumer also check that a pair held under back-pressure does not move while the walk waits.

// File: rtl/snl_pkg.sv
package snl_pkg;
  typedef enum logic [1:0] {
    SEL_GOLD = 2'd0,
    SEL_MAP  = 2'd1,
    SEL_NBR  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_SCAN    = 2'd1,
    ST_HOLD    = 2'd2
  } walk_state_e;
endpackage

// File: rtl/snl_table_store.sv
module snl_table_store #(
  parameter int N  = 8,
  parameter int M  = 4,
  parameter int AW = 3,
  parameter int NW = 2,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_data,
  input  logic [AW-1:0]   rd_row,
  output logic [N-1:0]    gold_q,
  output logic [N*NW-1:0] map_flat,
  output logic [M*M-1:0]  nbr_flat
);
  import snl_pkg::*;

  // golden rows: single write port, registered read (block RAM friendly)
  logic [N-1:0] gold_mem [N];

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == SEL_GOLD) gold_mem[cfg_addr] <= cfg_data[N-1:0];
    gold_q <= gold_mem[rd_row];
  end

  for (genvar p = 0; p < N; p++) begin : g_map
    logic [NW-1:0] net_idx;
    always_ff @(posedge clk) begin
      if (rst) net_idx <= '0;
      else if (cfg_we && cfg_sel == SEL_MAP && cfg_addr == AW'(p))
        net_idx <= cfg_data[NW-1:0];
    end
    assign map_flat[p*NW +: NW] = net_idx;
  end

  for (genvar r = 0; r < M; r++) begin : g_nbr
    logic [M-1:0] row_bits;
    always_ff @(posedge clk) begin
      if (rst) row_bits <= '0;
      else if (cfg_we && cfg_sel == SEL_NBR && cfg_addr == AW'(r))
        row_bits <= cfg_data[M-1:0];
    end
    assign nbr_flat[r*M +: M] = row_bits;
  end
endmodule

// File: rtl/snl_pair_fold.sv
module snl_pair_fold #(
  parameter int N  = 8,
  parameter int M  = 4,
  parameter int AW = 3,
  parameter int NW = 2
) (
  input  logic [AW-1:0]   row,
  input  logic [N-1:0]    bits,
  input  logic [N-1:0]    gold,
  input  logic [N*NW-1:0] map_flat,
  output logic [M*M-1:0]  pairs
);
  logic [NW-1:0] net_i;
  logic [NW-1:0] net_j;

  assign net_i = map_flat[int'(row)*NW +: NW];

  // undesigned edges only, folded onto the upper triangle of the net matrix
  always_comb begin
    pairs = '0;
    net_j = '0;
    for (int j = 0; j < N; j++) begin
      net_j = map_flat[j*NW +: NW];
      if (bits[j] && !gold[j] && net_i != net_j) begin
        if (net_i < net_j) pairs[int'(net_i)*M + int'(net_j)] = 1'b1;
        else               pairs[int'(net_j)*M + int'(net_i)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snl_pair_report.sv
module snl_pair_report #(
  parameter int M  = 4,
  parameter int NW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fold_en,
  input  logic           fold_last,
  input  logic [M*M-1:0] fold_pairs,
  input  logic [M*M-1:0] nbr_flat,
  output logic           busy,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [NW-1:0]  out_first,
  output logic [NW-1:0]  out_second,
  output logic           done
);
  import snl_pkg::*;

  walk_state_e   state;
  logic [M*M-1:0] acc;
  logic [NW-1:0] pa, pb, na, nb;
  logic          hit, last_pair, step;

  assign hit       = acc[int'(pa)*M + int'(pb)] & nbr_flat[int'(pa)*M + int'(pb)];
  assign last_pair = (pa == NW'(M-2)) && (pb == NW'(M-1));
  assign step      = (state == ST_SCAN && !hit) || (state == ST_HOLD && out_ready);
  assign busy      = (state != ST_COLLECT);

  always_comb begin
    if (pb == NW'(M-1)) begin
      na = pa + NW'(1);
      nb = pa + NW'(2);
    end else begin
      na = pa;
      nb = pb + NW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_COLLECT;
      acc        <= '0;
      pa         <= '0;
      pb         <= NW'(1);
      out_valid  <= 1'b0;
      out_first  <= '0;
      out_second <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_COLLECT: begin
          pa <= '0;
          pb <= NW'(1);
          if (fold_en) begin
            acc <= acc | fold_pairs;
            if (fold_last) state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            out_valid  <= 1'b1;
            out_first  <= pa;
            out_second <= pb;
            state      <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) out_valid <= 1'b0;
        end
        default: state <= ST_COLLECT;
      endcase
      if (step) begin
        if (last_pair) begin
          done  <= 1'b1;
          acc   <= '0;
          state <= ST_COLLECT;
        end else begin
          pa    <= na;
          pb    <= nb;
          state <= ST_SCAN;
        end
      end
    end
  end
endmodule

// File: rtl/snl_locator.sv
module snl_locator #(
  parameter int NPADS = 8,
  parameter int NNETS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [$clog2(NPADS)-1:0]   cfg_addr,
  input  logic [((NPADS > NNETS) ? NPADS : NNETS)-1:0] cfg_data,
  input  logic                       meas_valid,
  input  logic [$clog2(NPADS)-1:0]   meas_row,
  input  logic [NPADS-1:0]           meas_bits,
  input  logic                       meas_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(NNETS)-1:0]   out_first,
  output logic [$clog2(NNETS)-1:0]   out_second,
  output logic                       done
);
  localparam int AW = $clog2(NPADS);
  localparam int NW = $clog2(NNETS);
  localparam int CW = (NPADS > NNETS) ? NPADS : NNETS;

  logic [NPADS-1:0]    gold_q;
  logic [NPADS*NW-1:0] map_flat;
  logic [NNETS*NNETS-1:0] nbr_flat, fold_pairs;
  logic                busy, accept;
  logic                s1_valid, s1_last;
  logic [AW-1:0]       s1_row;
  logic [NPADS-1:0]    s1_bits;

  // rows after the flagged last one are dropped until the walk ends
  assign accept = meas_valid && !busy && !(s1_valid && s1_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_row   <= '0;
      s1_bits  <= '0;
    end else begin
      s1_valid <= accept;
      s1_last  <= meas_last;
      s1_row   <= meas_row;
      s1_bits  <= meas_bits;
    end
  end

  snl_table_store #(.N(NPADS), .M(NNETS), .AW(AW), .NW(NW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rd_row(meas_row),
    .gold_q(gold_q), .map_flat(map_flat), .nbr_flat(nbr_flat)
  );

  snl_pair_fold #(.N(NPADS), .M(NNETS), .AW(AW), .NW(NW)) u_fold (
    .row(s1_row), .bits(s1_bits), .gold(gold_q),
    .map_flat(map_flat), .pairs(fold_pairs)
  );

  snl_pair_report #(.M(NNETS), .NW(NW)) u_report (
    .clk(clk), .rst(rst), .fold_en(s1_valid), .fold_last(s1_last),
    .fold_pairs(fold_pairs), .nbr_flat(nbr_flat), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
    .out_second(out_second), .done(done)
  );
endmodule

// File: rtl/snl_locator_chk.sv
module snl_locator_chk #(
  parameter int NW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [NW-1:0] out_first,
  input logic [NW-1:0] out_second,
  input logic          done
);
  logic              have_prev;
  logic [2*NW-1:0]   prev_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_pair <= '0;
    end else if (done) begin
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      have_prev <= 1'b1;
      prev_pair <= {out_first, out_second};
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_first) && $stable(out_second));

  assert_pair_sorted_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_first < out_second);

  assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && have_prev |-> {out_first, out_second} > prev_pair);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_alone_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);
endmodule

bind snl_locator snl_locator_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_first(out_first), .out_second(out_second), .done(done)
);

// File: tb/sim_snl_locator.sv
module sim_snl_locator;
  localparam int N = 8;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic meas_valid = 1'b0;
  logic [2:0] meas_row = '0;
  logic [7:0] meas_bits = '0;
  logic meas_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [1:0] out_first, out_second;
  logic done;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [7:0] g_gold [N];
  logic [7:0] g_meas [N];
  logic [3:0] g_nbr  [M];
  int         g_map  [N];

  always #2 clk = ~clk;

  snl_locator #(.NPADS(N), .NNETS(M)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .meas_valid(meas_valid), .meas_row(meas_row),
    .meas_bits(meas_bits), .meas_last(meas_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_first(out_first), .out_second(out_second), .done(done)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int addr, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 3'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic load_tables();
    for (int i = 0; i < N; i++) cfg_write(0, i, g_gold[i]);
    for (int i = 0; i < N; i++) cfg_write(1, i, 8'(g_map[i]));
    for (int r = 0; r < M; r++) cfg_write(2, r, {4'b0, g_nbr[r]});
  endtask

  function automatic bit model_hit(input int a, input int b);
    if (!g_nbr[a][b]) return 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (g_meas[i][j] && !g_gold[i][j] && g_map[i] != g_map[j]) begin
          if ((g_map[i] == a && g_map[j] == b) || (g_map[i] == b && g_map[j] == a)) return 1'b1;
        end
    return 1'b0;
  endfunction

  // run one measurement; stall_mode 0: always ready, 1: pseudo-random ready
  task automatic run(input string tag, input int stall_mode, input bit garbage);
    int exp_a [6]; int exp_b [6]; int exp_n;
    int got_a [6]; int got_b [6]; int got_n;
    bit seen_done; bit prev_stall; int pf, ps;
    exp_n = 0; got_n = 0; seen_done = 0; prev_stall = 0; pf = 0; ps = 0;
    for (int a = 0; a < M; a++)
      for (int b = a + 1; b < M; b++)
        if (model_hit(a, b)) begin exp_a[exp_n] = a; exp_b[exp_n] = b; exp_n++; end
    load_tables();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      meas_valid = 1'b1; meas_row = 3'(i); meas_bits = g_meas[i]; meas_last = (i == N-1);
    end
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (garbage && c < 3) begin
        meas_valid = 1'b1; meas_row = 3'(c); meas_bits = 8'hFF; meas_last = 1'b1;
      end else begin
        meas_valid = 1'b0; meas_last = 1'b0;
      end
      out_ready = (stall_mode == 0) ? 1'b1 : rnd()[3];
      if (prev_stall) begin
        check(out_valid == 1'b1, "R6", "valid dropped under stall", int'(out_valid), 1);
        check(int'(out_first) == pf && int'(out_second) == ps, "R6", "pair moved under stall",
              int'(out_first) * 10 + int'(out_second), pf * 10 + ps);
      end
      prev_stall = out_valid && !out_ready;
      pf = int'(out_first); ps = int'(out_second);
      if (out_valid && out_ready) begin
        if (got_n < 6) begin got_a[got_n] = int'(out_first); got_b[got_n] = int'(out_second); end
        got_n++;
      end
      if (done) begin
        check(!out_valid, "R7", "valid with done", int'(out_valid), 0);
        seen_done = 1'b1;
        break;
      end
    end
    out_ready = 1'b0;
    check(seen_done, tag, "done strobe seen", int'(seen_done), 1);
    check(got_n == exp_n, tag, "pair count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      check(got_a[k] == exp_a[k] && got_b[k] == exp_b[k], tag, "pair (first*10+second)",
            got_a[k] * 10 + got_b[k], exp_a[k] * 10 + exp_b[k]);
    @(negedge clk);
    check(done == 1'b0, "R7", "done longer than one cycle", int'(done), 0);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin g_gold[i] = '0; g_meas[i] = '0; g_map[i] = i / 2; end
    for (int r = 0; r < M; r++) g_nbr[r] = 4'hF;
  endtask

  task automatic set_edge(input int i, input int j);
    g_meas[i][j] = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    check(done == 1'b0, "R10", "done after reset", int'(done), 0);

    // R1: designed cross-net link is masked, undesigned one survives
    clear_all();
    g_gold[1][2] = 1'b1; set_edge(1, 2);
    set_edge(4, 6);
    run("R1", 0, 0);

    // R2: same-net pad edges
    clear_all();
    set_edge(0, 1); set_edge(5, 4); set_edge(7, 6);
    run("R2", 0, 0);

    // R3: many edges on one net pair, both orientations
    clear_all();
    set_edge(0, 2); set_edge(0, 3); set_edge(1, 2); set_edge(3, 1); set_edge(2, 0);
    run("R3", 0, 0);

    // R4: neighbour filter, lower-triangle bits ignored
    clear_all();
    set_edge(0, 4); set_edge(2, 6); set_edge(4, 6);
    g_nbr[0] = 4'b0100; g_nbr[1] = 4'b0000; g_nbr[2] = 4'b0100; g_nbr[3] = 4'b1111;
    run("R4", 0, 0);

    // R5/R6: every cross pair, stalling consumer
    clear_all();
    for (int i = 0; i < N; i++) g_meas[i] = 8'hFF;
    run("R5", 1, 0);

    // R8/R9: only short lives in the last row, rows after it are junk
    clear_all();
    set_edge(7, 0);
    run("R9", 0, 1);
    clear_all();
    run("R8", 0, 0);

    // sweep of pseudo-random tables
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) begin
        g_gold[i] = 8'(rnd()) & 8'(rnd());
        g_meas[i] = 8'(rnd()) & 8'(rnd()) & 8'(rnd());
        g_map[i]  = int'(rnd() % 32'(M));
      end
      for (int r = 0; r < M; r++) g_nbr[r] = 4'(rnd());
      run("R5", t % 2, t % 3 == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule